// File: doc/BRIEF.md
# Transmit Phase-Align Elastic Buffer

This block carries a stream of transmit characters from the clock that delivers them into the internal character-rate clock. The two clocks run at the same frequency, but their phase relationship is unknown. The writer stores one character on every write-clock edge into a small ring of registers. The reader takes one character out on every read-clock edge. The pointers cross between the domains in Gray code through two-flop synchronizers. The reader waits until a quarter of the ring is filled before it starts, so that it settles near the middle of the ring.

If the two clocks drift, the ring can fill up or run dry. In that case a sticky fault flag is raised and the stream is patched. A write into a full ring drops the incoming character. A read from an empty ring repeats the last character. The flag stays set until one of two things happens: the pointers are re-centred by an active-low phase-reset input, or the read side receives a pulse reporting that a word-sync sequence has been completed. The phase reset only takes effect when it is sampled low on two consecutive write-clock edges. While it is held low, characters may be dropped or repeated. When both clock-mode inputs are low, the ring is bypassed entirely: characters are registered straight on the read clock, and the phase reset is ignored.

Top module: `tx_phase_align`

## Requirements
- R1: While either reset is asserted, and in the first read cycle after both resets are released, `rd_char` is 0 and `fault` is 0.
- R2: In buffer mode (`clk_sel`=1, or `clk_sel`=0 with `rate_sel`=1), with equal clock frequencies and no fault, each character written is output exactly once and in order: each read-cycle value of `rd_char` is the previous value plus 1 when the input counts up by 1 per write cycle.
- R3: After a reset or a re-centre, the reader starts only once a quarter of the ring is visible as filled. With the default 16-entry ring, the steady distance from the current input character to `rd_char` is 5 to 13 characters.
- R4: When `phase_rst_n` is sampled low on two consecutive write-clock edges, the write pointer is cleared, the reader is held and restarts with the R3 fill, and `fault` is cleared. A low seen on a single edge has no effect: the stream and its latency are unchanged.
- R5: A write into a full ring drops that character, so the output skips a value, and sets `fault`.
- R6: A read from an empty ring repeats the previous `rd_char`, so nothing is lost, and sets `fault`.
- R7: Once set, `fault` stays at 1 until a re-centre or a one-cycle `sync_done` pulse on the read clock. After such a pulse it stays 0 while no new overflow or underflow occurs.
- R8: In bypass mode (`clk_sel`=0 and `rate_sel`=0), `rd_char` equals the `wr_char` sampled on the previous read-clock edge, `phase_rst_n` is ignored, and `fault` is 0.
- R9: Leaving bypass for buffer mode restarts the ring as a re-centre does. The stream then passes as in R2, with the latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write (character input) clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| rclk | input | 1 | Read (internal character-rate) clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| clk_sel | input | 1 | Clock-source mode select; with `rate_sel` low and this low, the ring is bypassed |
| rate_sel | input | 1 | Rate mode select; high keeps the ring in use |
| phase_rst_n | input | 1 | Active-low re-centre request, sampled on `wclk` |
| wr_char | input | CW | Input character (on `wclk` in buffer mode, on `rclk` in bypass) |
| sync_done | input | 1 | One-cycle pulse on `rclk`: word-sync sequence completed, clears the fault |
| rd_char | output | CW | Output character on `rclk` |
| fault | output | 1 | Sticky overflow/underflow indication |

## Verification
The ring is driven with a counting character stream under four clock relationships. Equal periods must give a gap-free sequence with a fixed latency. A read clock faster than the write clock must produce repeats and no skips (underflow). A write clock faster than the read clock must produce skips and no repeats (overflow). A synchronous bypass stream must be echoed one cycle later. A one-edge low on the phase reset must leave the latency exactly unchanged, while a held low must pull the latency back into the centred window and clear the fault. This separates a working two-edge qualifier and recentring from a broken one. Holding the fault through a recovered clock relationship, then clearing it with the sync pulse, separates the sticky flag from a level that merely follows the current condition.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

    // Clock-mode configuration seen at the top-level pins.
    typedef struct packed {
        logic clk_sel;
        logic rate_sel;
    } clk_cfg_t;

    // Read-side sequencing.
    typedef enum logic [1:0] {
        RD_HOLD  = 2'd0,   // held by a re-centre request
        RD_PRIME = 2'd1,   // waiting for the ring to fill to the start level
        RD_RUN   = 2'd2    // one character per read clock
    } rd_state_e;

    // The ring is skipped when both mode inputs are low.
    function automatic logic is_bypass(clk_cfg_t cfg);
        return (cfg.clk_sel == 1'b0) && (cfg.rate_sel == 1'b0);
    endfunction

endpackage

// File: rtl/tpa_sync.sv
module tpa_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/tpa_store.sv
module tpa_store #(
    parameter int CW = 10,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [CW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [CW-1:0] ring [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) ring[waddr] <= wdata;
    end

    assign rdata = ring[raddr];
endmodule

// File: rtl/tpa_wr_side.sv
module tpa_wr_side #(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          bypass,
    input  logic          phase_rst_n,
    input  logic [AW:0]   rgray_s,
    input  logic          ack_s,
    output logic          we,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output logic          req,
    output logic          hold,
    output logic          full,
    output logic          ovf_tgl
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);

    logic          ph_q1, ph_q2;
    logic [PW-1:0] rbin;
    logic [PW-1:0] occ;
    logic [PW-1:0] wptr_inc;

    // Pin samples on two successive edges; both must be low to re-centre.
    always_ff @(posedge wclk) begin
        if (wrst) begin
            ph_q1 <= 1'b1;
            ph_q2 <= 1'b1;
            req   <= 1'b0;
        end else begin
            ph_q1 <= phase_rst_n;
            ph_q2 <= ph_q1;
            req   <= bypass | (~ph_q1 & ~ph_q2);
        end
    end

    // Writer stays parked until the reader has acknowledged and released.
    assign hold = req | ack_s;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
    end

    assign occ      = wptr - rbin;
    assign full     = (occ == FULL_OCC);
    assign we       = ~hold & ~full;
    assign wptr_inc = wptr + 1'b1;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wptr    <= '0;
            wgray   <= '0;
            ovf_tgl <= 1'b0;
        end else if (hold) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (full) begin
            ovf_tgl <= ~ovf_tgl;
        end else begin
            wptr  <= wptr_inc;
            wgray <= wptr_inc ^ (wptr_inc >> 1);
        end
    end
endmodule

// File: rtl/tpa_rd_side.sv
module tpa_rd_side
    import tpa_pkg::*;
#(
    parameter int CW = 10,
    parameter int AW = 4
) (
    input  logic          rclk,
    input  logic          rrst,
    input  logic          hold_r,
    input  logic [AW:0]   wgray_s,
    input  logic          ovf_evt,
    input  logic          sync_done,
    input  logic [CW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          ack,
    output logic [CW-1:0] rd_q,
    output logic          fault_q,
    output logic          uflow
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] START_OCC = PW'(DEPTH / 4);

    rd_state_e     st;
    logic [PW-1:0] rptr;
    logic [PW-1:0] rptr_inc;
    logic [PW-1:0] wbin;
    logic [PW-1:0] occ;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
    end

    assign occ      = wbin - rptr;
    assign rptr_inc = rptr + 1'b1;
    assign raddr    = rptr[AW-1:0];
    assign uflow    = (st == RD_RUN) && !hold_r && (occ == '0);

    always_ff @(posedge rclk) begin
        if (rrst) begin
            st    <= RD_PRIME;
            rptr  <= '0;
            rgray <= '0;
            rd_q  <= '0;
            ack   <= 1'b0;
        end else begin
            ack <= hold_r;
            if (hold_r) begin
                st    <= RD_HOLD;
                rptr  <= '0;
                rgray <= '0;
            end else begin
                case (st)
                    RD_HOLD:  st <= RD_PRIME;
                    RD_PRIME: if (occ >= START_OCC) st <= RD_RUN;
                    RD_RUN: begin
                        if (occ != '0) begin
                            rd_q  <= rdata;
                            rptr  <= rptr_inc;
                            rgray <= rptr_inc ^ (rptr_inc >> 1);
                        end
                    end
                    default: st <= RD_HOLD;
                endcase
            end
        end
    end

    // Sticky fault: a new error wins over a clear in the same cycle.
    always_ff @(posedge rclk) begin
        if (rrst)                   fault_q <= 1'b0;
        else if (uflow || ovf_evt)  fault_q <= 1'b1;
        else if (hold_r || sync_done) fault_q <= 1'b0;
    end
endmodule

// File: rtl/tx_phase_align.sv
module tx_phase_align
    import tpa_pkg::*;
#(
    parameter int CW = 10,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          clk_sel,
    input  logic          rate_sel,
    input  logic          phase_rst_n,
    input  logic [CW-1:0] wr_char,
    input  logic          sync_done,
    output logic [CW-1:0] rd_char,
    output logic          fault
);
    localparam int PW = AW + 1;

    clk_cfg_t      cfg;
    logic          byp;
    logic          we;
    logic [PW-1:0] wptr;
    logic [PW-1:0] wgray, wgray_s;
    logic [PW-1:0] rgray, rgray_s;
    logic [AW-1:0] raddr;
    logic [CW-1:0] rdata;
    logic          req_w, w_hold, full, ovf_tgl;
    logic          rd_hold, ack_r, ack_s;
    logic          tgl_s, tgl_prev, ovf_evt;
    logic          uflow, fault_q;
    logic [CW-1:0] rd_q, byp_q;

    assign cfg = '{clk_sel: clk_sel, rate_sel: rate_sel};
    assign byp = is_bypass(cfg);

    tpa_wr_side #(.AW(AW)) u_wr (
        .wclk(wclk), .wrst(wrst), .bypass(byp), .phase_rst_n(phase_rst_n),
        .rgray_s(rgray_s), .ack_s(ack_s), .we(we), .wptr(wptr), .wgray(wgray),
        .req(req_w), .hold(w_hold), .full(full), .ovf_tgl(ovf_tgl)
    );

    tpa_store #(.CW(CW), .AW(AW)) u_ring (
        .wclk(wclk), .we(we), .waddr(wptr[AW-1:0]), .wdata(wr_char),
        .raddr(raddr), .rdata(rdata)
    );

    // Crossings into the read domain.
    tpa_sync #(.W(PW)) u_s_wg  (.clk(rclk), .rst(rrst), .d(wgray),   .q(wgray_s));
    tpa_sync #(.W(1))  u_s_req (.clk(rclk), .rst(rrst), .d(req_w),   .q(rd_hold));
    tpa_sync #(.W(1))  u_s_ovf (.clk(rclk), .rst(rrst), .d(ovf_tgl), .q(tgl_s));

    // Crossings into the write domain.
    tpa_sync #(.W(PW)) u_s_rg  (.clk(wclk), .rst(wrst), .d(rgray),   .q(rgray_s));
    tpa_sync #(.W(1))  u_s_ack (.clk(wclk), .rst(wrst), .d(ack_r),   .q(ack_s));

    always_ff @(posedge rclk) begin
        if (rrst) tgl_prev <= 1'b0;
        else      tgl_prev <= tgl_s;
    end
    assign ovf_evt = tgl_s ^ tgl_prev;

    tpa_rd_side #(.CW(CW), .AW(AW)) u_rd (
        .rclk(rclk), .rrst(rrst), .hold_r(rd_hold), .wgray_s(wgray_s),
        .ovf_evt(ovf_evt), .sync_done(sync_done), .rdata(rdata),
        .raddr(raddr), .rgray(rgray), .ack(ack_r), .rd_q(rd_q),
        .fault_q(fault_q), .uflow(uflow)
    );

    // Bypass path: input treated as read-clock synchronous.
    always_ff @(posedge rclk) begin
        if (rrst) byp_q <= '0;
        else      byp_q <= wr_char;
    end

    assign rd_char = byp ? byp_q : rd_q;
    assign fault   = fault_q & ~byp;
endmodule

// File: rtl/tpa_checker.sv
module tpa_checker #(
    parameter int CW = 10,
    parameter int AW = 4
) (
    input logic          wclk,
    input logic          wrst,
    input logic          rclk,
    input logic          rrst,
    input logic          byp,
    input logic          phase_rst_n,
    input logic [CW-1:0] wr_char,
    input logic [CW-1:0] rd_char,
    input logic          fault,
    input logic          sync_done,
    input logic          req_w,
    input logic          w_hold,
    input logic          full,
    input logic [AW:0]   wptr,
    input logic          uflow,
    input logic          rd_hold
);
    // R8: bypass echoes the previous read-edge input
    a_r8_bypass_echo: assert property (@(posedge rclk) disable iff (rrst)
        (byp && $past(byp) && !$past(rrst)) |-> (rd_char == $past(wr_char)));

    // R6: an underflow holds the output and raises the fault
    a_r6_uflow_holds: assert property (@(posedge rclk) disable iff (rrst)
        (uflow && !byp) |=> ($stable(rd_char) || byp));
    a_r6_uflow_fault: assert property (@(posedge rclk) disable iff (rrst)
        uflow |=> (fault || byp));

    // R7: the fault persists without a clearing event
    a_r7_fault_sticky: assert property (@(posedge rclk) disable iff (rrst)
        (fault && !sync_done && !rd_hold) |=> (fault || byp));

    // R5: a write into a full ring does not advance the write pointer
    a_r5_no_overflow: assert property (@(posedge wclk) disable iff (wrst)
        (full && !w_hold) |=> $stable(wptr));

    // R4: a held writer sits at pointer zero
    a_r4_hold_clears: assert property (@(posedge wclk) disable iff (wrst)
        w_hold |=> (wptr == '0));

    // R4: a pin-driven re-centre needs two consecutive low samples
    a_r4_two_lows: assert property (@(posedge wclk) disable iff (wrst)
        ($rose(req_w) && !$past(byp)) |-> (!$past(phase_rst_n, 2) && !$past(phase_rst_n, 3)));
endmodule

bind tx_phase_align tpa_checker #(.CW(CW), .AW(AW)) u_chk (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst), .byp(byp),
    .phase_rst_n(phase_rst_n), .wr_char(wr_char), .rd_char(rd_char),
    .fault(fault), .sync_done(sync_done), .req_w(req_w), .w_hold(w_hold),
    .full(full), .wptr(wptr), .uflow(uflow), .rd_hold(rd_hold)
);

// File: tb/sim_tx_phase_align.sv
`timescale 1ps/1ps
module sim_tx_phase_align;
    localparam int CW = 10;
    localparam int AW = 4;
    localparam int MASK = (1 << CW) - 1;

    logic wclk = 1'b0, rclk = 1'b0;
    int   whalf = 4000;

    initial begin
        #1300;
        forever #(whalf) wclk = ~wclk;
    end
    always #4000 rclk = ~rclk;

    logic          wrst, rrst, clk_sel, rate_sel, phase_rst_n, sync_done;
    logic [CW-1:0] wr_char, rd_char;
    logic          fault;
    logic [CW-1:0] wseq = '0, rseq = '0;

    always @(negedge wclk) wseq <= wseq + 1'b1;
    always @(negedge rclk) rseq <= rseq + 1'b1;
    assign wr_char = (!clk_sel && !rate_sel) ? rseq : wseq;

    tx_phase_align #(.CW(CW), .AW(AW)) u0 (
        .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
        .clk_sel(clk_sel), .rate_sel(rate_sel), .phase_rst_n(phase_rst_n),
        .wr_char(wr_char), .sync_done(sync_done),
        .rd_char(rd_char), .fault(fault)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge rclk);
        #1;
    endtask

    function automatic int lat();
        return (int'(wseq) - int'(rd_char)) & MASK;
    endfunction

    task automatic chk_stream(input string req, input int n);
        int prev = int'(rd_char);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(((int'(rd_char) - prev) & MASK) == 1, req, (int'(rd_char) - prev) & MASK, 1);
            prev = int'(rd_char);
        end
    endtask

    task automatic t_reset();
        wrst = 1; rrst = 1; clk_sel = 1; rate_sel = 0;
        phase_rst_n = 1; sync_done = 0;
        repeat (6) tick();
        chk(rd_char == '0, "R1 rd_char in reset", int'(rd_char), 0);
        chk(fault == 1'b0, "R1 fault in reset", int'(fault), 0);
        wrst = 0; rrst = 0;
        tick();
        chk(rd_char == '0, "R1 rd_char after release", int'(rd_char), 0);
        chk(fault == 1'b0, "R1 fault after release", int'(fault), 0);
    endtask

    task automatic t_run(input string req);
        repeat (80) tick();
        chk_stream(req, 64);
        chk(lat() >= 5 && lat() <= 13, {req, " R3 latency"}, lat(), 9);
        chk(fault == 1'b0, {req, " fault"}, int'(fault), 0);
    endtask

    task automatic t_single_low();
        int l0;
        l0 = lat();
        @(negedge wclk); phase_rst_n = 0;
        @(negedge wclk); phase_rst_n = 1;
        chk_stream("R4 single low ignored", 100);
        chk(lat() == l0, "R4 single low latency", lat(), l0);
        chk(fault == 1'b0, "R4 single low fault", int'(fault), 0);
    endtask

    task automatic recentre();
        @(negedge wclk); phase_rst_n = 0;
        repeat (8) @(negedge wclk);
        phase_rst_n = 1;
    endtask

    task automatic t_underflow();
        int prev, d, dups = 0, skips = 0;
        bit seen = 0;
        whalf = 4200;
        prev = int'(rd_char);
        for (int i = 0; i < 400; i++) begin
            tick();
            d = (int'(rd_char) - prev) & MASK;
            if (d == 0) dups++;
            else if (d != 1) skips++;
            if (fault) seen = 1;
            prev = int'(rd_char);
        end
        chk(dups > 0, "R6 repeats on underflow", dups, 1);
        chk(skips == 0, "R6 nothing lost on underflow", skips, 0);
        chk(seen, "R6 fault on underflow", int'(seen), 1);
        whalf = 4000;
        repeat (100) tick();
        recentre();
        repeat (3) tick();
        chk(fault == 1'b0, "R4 recentre clears fault", int'(fault), 0);
        repeat (80) tick();
        chk(lat() >= 5 && lat() <= 13, "R4 R3 latency after recentre", lat(), 9);
        chk_stream("R4 stream after recentre", 64);
        chk(fault == 1'b0, "R4 fault stays clear", int'(fault), 0);
    endtask

    task automatic t_overflow();
        int prev, d, dups = 0, skips = 0;
        bit seen = 0;
        whalf = 3800;
        prev = int'(rd_char);
        for (int i = 0; i < 400; i++) begin
            tick();
            d = (int'(rd_char) - prev) & MASK;
            if (d == 0) dups++;
            else if (d != 1) skips++;
            if (fault) seen = 1;
            prev = int'(rd_char);
        end
        chk(skips > 0, "R5 skips on overflow", skips, 1);
        chk(dups == 0, "R5 no repeats on overflow", dups, 0);
        chk(seen, "R5 fault on overflow", int'(seen), 1);
        whalf = 4000;
        repeat (100) tick();
        chk(fault == 1'b1, "R7 fault sticky", int'(fault), 1);
        sync_done = 1;
        tick();
        sync_done = 0;
        tick();
        chk(fault == 1'b0, "R7 sync_done clears fault", int'(fault), 0);
        chk_stream("R7 stream after clear", 64);
        chk(fault == 1'b0, "R7 fault stays clear", int'(fault), 0);
    endtask

    task automatic t_bypass();
        clk_sel = 0; rate_sel = 0;
        repeat (4) tick();
        phase_rst_n = 0;
        for (int i = 0; i < 50; i++) begin
            tick();
            chk(rd_char == rseq - 1'b1, "R8 bypass echo", int'(rd_char), int'(rseq - 1'b1));
            chk(fault == 1'b0, "R8 bypass fault", int'(fault), 0);
        end
        phase_rst_n = 1;
    endtask

    task automatic t_back();
        rate_sel = 1;
        t_run("R9 buffer after bypass");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_run("R2 stream");
                t_single_low();
                t_underflow();
                t_overflow();
                t_bypass();
                t_back();
            end
            begin
                repeat (150000) @(posedge rclk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule